// File: doc/BRIEF.md
# H-Bridge Mode and Fault Controller

This block is the synchronous control core of a full H-bridge power stage. It turns a PWM command, a direction command and a disable request into upper and lower gate enables for two half-bridges, called leg A and leg B. Two decodes are available. In sign/magnitude (2-quadrant) operation one leg is held on its upper switch while the other chops. In locked anti-phase (4-quadrant) operation the modulation arrives on the direction input and both legs switch in opposition. Each leg puts a fixed dead time between releasing one switch and closing the other.

The block also guards the bridge. A short-circuit or over-temperature detector, each gated by its own enable strap, latches every switch open and raises a combined fault flag and a per-cause flag. The latch clears when the disable input goes high and then low again. An over-current comparator bit opens the bridge for the rest of the present switching cycle, and a cycle-start strobe releases it. The comparator is not examined for a short window after any gate change, because switching spikes would cause false trips.

The PWM, direction and disable inputs each pass through a synchronizer before any decoding. The detector, comparator and strobe inputs are taken as synchronous to the clock. The mode select and the enable straps are static.

Top module: `hbridge_ctrl`

## Requirements
- R1: With `fourQuad`=0 and the direction input high, leg A is held on its upper switch. Leg B closes its lower switch while PWM is 1 and its upper switch while PWM is 0. A command change at `pwmIn`/`dirIn` is sampled by the clock edge that follows it. The resulting switch turn-on appears at the second edge after that one, provided no dead time is pending.
- R2: With `fourQuad`=0 and the direction input low, the roles are mirrored. Leg B is held on its upper switch, and leg A closes its lower switch while PWM is 1 and its upper switch while PWM is 0.
- R3: In 2-quadrant operation with PWM held at 0, both upper switches are on and both lower switches are off (braking).
- R4: With `fourQuad`=1, leg A is on its upper switch and leg B on its lower switch while the direction input is 1. The two are swapped while it is 0. The PWM input has no effect in this mode.
- R5: The upper and lower enables of one leg are never both 1. When a leg changes over, both of its enables stay 0 for exactly DEAD_CYCLES clock cycles (DEAD_CYCLES ≥ 1).
- R6: While the synchronized disable input is 1, all four enables are 0.
- R7: A 1 on `scDetect` (with `scEnable`=1) or on `otDetect` (with `otEnable`=1) at a clock edge sets `scFlag` or `otFlag` after that edge. `faultFlag` equals the OR of the two flags. All four enables are 0 from the next edge on, and the flags hold after the detector input returns to 0.
- R8: A 1-to-0 transition of the synchronized disable input clears both latched flags. A set request in the same cycle wins over the clear.
- R9: A detector whose enable strap is 0 never sets its flag or opens the bridge.
- R10: An over-current bit accepted at an edge makes all four enables 0 from the following edge. This lasts until a `cycleStart` pulse, and the bridge then resumes normal operation. `faultFlag` stays 0 throughout.
- R11: `ocTrip` is ignored in a clock cycle if any gate enable changed at that cycle's start or at any of the BLANK_CYCLES edges before it.
- R12: After reset all enables and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmIn | input | 1 | PWM command (asynchronous) |
| dirIn | input | 1 | Direction command, or modulation in 4-quadrant mode (asynchronous) |
| disableIn | input | 1 | Forces the bridge off; its high-then-low sequence clears faults (asynchronous) |
| fourQuad | input | 1 | 0 = sign/magnitude decode, 1 = locked anti-phase decode |
| scDetect | input | 1 | Short-circuit detector output |
| otDetect | input | 1 | Over-temperature detector output |
| scEnable | input | 1 | Strap enabling short-circuit protection |
| otEnable | input | 1 | Strap enabling over-temperature protection |
| ocTrip | input | 1 | Over-current comparator output |
| cycleStart | input | 1 | One-cycle strobe at the start of each switching period |
| highA | output | 1 | Leg A upper switch enable |
| lowA | output | 1 | Leg A lower switch enable |
| highB | output | 1 | Leg B upper switch enable |
| lowB | output | 1 | Leg B lower switch enable |
| faultFlag | output | 1 | A protection fault is latched |
| scFlag | output | 1 | Short-circuit fault latched |
| otFlag | output | 1 | Over-temperature fault latched |

## Verification
The hardest case to reach is the blanking window. An over-current bit must land inside the few cycles after a gate edge, and that edge comes from a command that first passes the synchronizer and then the dead-time counter. The stimulus flips PWM and counts the exact number of edges to the release of the lower switch. It then holds `ocTrip` high across the following cycles, so the trip covers both the blanked window and the dead-time turn-on. The bench checks that the bridge keeps switching instead of being cut off. A second sequence first lets the bridge settle, then trips the comparator with blanking expired, and releases it with a manually placed cycle-start strobe.

// File: rtl/hbridge_pkg.sv
package hbridge_pkg;

  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } legCmd_t;

  typedef struct packed {
    legCmd_t legA;
    legCmd_t legB;
  } bridgeCmd_t;

endpackage

// File: rtl/hb_leg.sv
module hb_leg
  import hbridge_pkg::*;
#(
  parameter int DEAD_CYCLES = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  legCmd_t cmd,
  output logic    hiOn,
  output logic    loOn
);

  localparam int DT_W = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;
  localparam logic [DT_W-1:0] DT_LOAD = DT_W'(DEAD_CYCLES - 1);

  logic [DT_W-1:0] dtCnt;
  logic hiRelease, loRelease;

  assign hiRelease = hiOn && (cmd != LEG_HIGH);
  assign loRelease = loOn && (cmd != LEG_LOW);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiOn  <= 1'b0;
      loOn  <= 1'b0;
      dtCnt <= '0;
    end else if (hiRelease || loRelease) begin
      hiOn  <= hiOn && !hiRelease;
      loOn  <= loOn && !loRelease;
      dtCnt <= DT_LOAD;
    end else if (dtCnt != '0) begin
      dtCnt <= dtCnt - 1'b1;
    end else begin
      hiOn <= (cmd == LEG_HIGH) && !loOn;
      loOn <= (cmd == LEG_LOW) && !hiOn;
    end
  end

endmodule

// File: rtl/hb_datapath.sv
module hb_datapath
  import hbridge_pkg::*;
#(
  parameter int DEAD_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  bridgeCmd_t cmd,
  output logic [1:0] gateHi,
  output logic [1:0] gateLo,
  output logic       gateMoved
);

  localparam int N_LEGS = 2;

  legCmd_t legCmds [N_LEGS];
  logic [2*N_LEGS-1:0] prevGates;

  assign legCmds[0] = cmd.legA;
  assign legCmds[1] = cmd.legB;

  genvar g;
  generate
    for (g = 0; g < N_LEGS; g++) begin : gLeg
      hb_leg #(.DEAD_CYCLES(DEAD_CYCLES)) u_leg (
        .clk  (clk),
        .rstN (rstN),
        .cmd  (legCmds[g]),
        .hiOn (gateHi[g]),
        .loOn (gateLo[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevGates <= '0;
    else       prevGates <= {gateHi, gateLo};
  end

  assign gateMoved = ({gateHi, gateLo} != prevGates);

endmodule

// File: rtl/hb_control.sv
module hb_control
  import hbridge_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int BLANK_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwmIn,
  input  logic       dirIn,
  input  logic       disableIn,
  input  logic       fourQuad,
  input  logic       scDetect,
  input  logic       otDetect,
  input  logic       scEnable,
  input  logic       otEnable,
  input  logic       ocTrip,
  input  logic       cycleStart,
  input  logic       gateMoved,
  output bridgeCmd_t cmd,
  output logic       scFlag,
  output logic       otFlag,
  output logic       faultFlag
);

  localparam int N_SYNC  = 3;
  localparam int BLANK_W = (BLANK_CYCLES > 0) ? $clog2(BLANK_CYCLES + 1) : 1;
  localparam logic [BLANK_W-1:0] BLANK_LOAD = BLANK_W'(BLANK_CYCLES);

  logic [N_SYNC-1:0] rawIn, syncOut;
  logic pwmS, dirS, disS, disPrev, faultClear;
  logic scLatch, otLatch, ocHold, ocAccept, bridgeOff;
  logic [BLANK_W-1:0] blankCnt;

  assign rawIn = {disableIn, dirIn, pwmIn};

  genvar g;
  generate
    for (g = 0; g < N_SYNC; g++) begin : gSync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], rawIn[g]};
      end
      assign syncOut[g] = chain[SYNC_STAGES-1];
    end
  endgenerate

  assign pwmS = syncOut[0];
  assign dirS = syncOut[1];
  assign disS = syncOut[2];

  assign faultClear = disPrev && !disS;
  assign ocAccept   = ocTrip && !gateMoved && (blankCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      disPrev  <= 1'b0;
      scLatch  <= 1'b0;
      otLatch  <= 1'b0;
      ocHold   <= 1'b0;
      blankCnt <= '0;
    end else begin
      disPrev <= disS;
      scLatch <= (scLatch && !faultClear) || (scDetect && scEnable);
      otLatch <= (otLatch && !faultClear) || (otDetect && otEnable);
      ocHold  <= cycleStart ? 1'b0 : (ocHold || ocAccept);
      if (gateMoved)             blankCnt <= BLANK_LOAD;
      else if (blankCnt != '0)   blankCnt <= blankCnt - 1'b1;
    end
  end

  assign bridgeOff = disS || scLatch || otLatch || ocHold;

  always_comb begin
    cmd.legA = LEG_OFF;
    cmd.legB = LEG_OFF;
    if (!bridgeOff) begin
      if (fourQuad) begin
        cmd.legA = dirS ? LEG_HIGH : LEG_LOW;
        cmd.legB = dirS ? LEG_LOW : LEG_HIGH;
      end else if (dirS) begin
        cmd.legA = LEG_HIGH;
        cmd.legB = pwmS ? LEG_LOW : LEG_HIGH;
      end else begin
        cmd.legB = LEG_HIGH;
        cmd.legA = pwmS ? LEG_LOW : LEG_HIGH;
      end
    end
  end

  assign scFlag    = scLatch;
  assign otFlag    = otLatch;
  assign faultFlag = scLatch || otLatch;

endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hbridge_pkg::*;
#(
  parameter int DEAD_CYCLES  = 3,
  parameter int BLANK_CYCLES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwmIn,
  input  logic dirIn,
  input  logic disableIn,
  input  logic fourQuad,
  input  logic scDetect,
  input  logic otDetect,
  input  logic scEnable,
  input  logic otEnable,
  input  logic ocTrip,
  input  logic cycleStart,
  output logic highA,
  output logic lowA,
  output logic highB,
  output logic lowB,
  output logic faultFlag,
  output logic scFlag,
  output logic otFlag
);

  bridgeCmd_t cmd;
  logic [1:0] gateHi, gateLo;
  logic gateMoved;

  hb_control #(
    .SYNC_STAGES  (SYNC_STAGES),
    .BLANK_CYCLES (BLANK_CYCLES)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .pwmIn      (pwmIn),
    .dirIn      (dirIn),
    .disableIn  (disableIn),
    .fourQuad   (fourQuad),
    .scDetect   (scDetect),
    .otDetect   (otDetect),
    .scEnable   (scEnable),
    .otEnable   (otEnable),
    .ocTrip     (ocTrip),
    .cycleStart (cycleStart),
    .gateMoved  (gateMoved),
    .cmd        (cmd),
    .scFlag     (scFlag),
    .otFlag     (otFlag),
    .faultFlag  (faultFlag)
  );

  hb_datapath #(.DEAD_CYCLES(DEAD_CYCLES)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .gateHi    (gateHi),
    .gateLo    (gateLo),
    .gateMoved (gateMoved)
  );

  assign highA = gateHi[0];
  assign lowA  = gateLo[0];
  assign highB = gateHi[1];
  assign lowB  = gateLo[1];

endmodule

// File: rtl/hb_checker.sv
module hb_checker (
  input logic clk,
  input logic rstN,
  input logic scDetect,
  input logic otDetect,
  input logic scEnable,
  input logic otEnable,
  input logic highA,
  input logic lowA,
  input logic highB,
  input logic lowB,
  input logic faultFlag,
  input logic scFlag,
  input logic otFlag
);

  AST_LEG_A_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(highA && lowA)); // R5
  AST_LEG_B_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(highB && lowB)); // R5
  AST_LOW_A_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lowA) |-> !$past(highA)); // R5
  AST_HIGH_B_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(highB) |-> !$past(lowB)); // R5
  AST_FAULT_OPENS_BRIDGE: assert property (@(posedge clk) disable iff (!rstN)
    faultFlag |=> !(highA || lowA || highB || lowB)); // R7
  AST_SC_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(scFlag) |-> $past(scDetect)); // R7
  AST_SC_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (!scEnable && !scFlag) |=> !scFlag); // R9
  AST_OT_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (!otEnable && !otFlag) |=> !otFlag); // R9

endmodule

bind hbridge_ctrl hb_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .scDetect  (scDetect),
  .otDetect  (otDetect),
  .scEnable  (scEnable),
  .otEnable  (otEnable),
  .highA     (highA),
  .lowA      (lowA),
  .highB     (highB),
  .lowB      (lowB),
  .faultFlag (faultFlag),
  .scFlag    (scFlag),
  .otFlag    (otFlag)
);

// File: tb/hbridge_ctrl_bench.sv
module hbridge_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEAD  = 3;
  localparam int BLANK = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwmIn = 1'b0, dirIn = 1'b0, disableIn = 1'b0, fourQuad = 1'b0;
  logic scDetect = 1'b0, otDetect = 1'b0, scEnable = 1'b1, otEnable = 1'b1;
  logic ocTrip = 1'b0, cycleStart;
  logic highA, lowA, highB, lowB, faultFlag, scFlag, otFlag;

  logic autoStart = 1'b1, manualStart = 1'b0, autoPulse = 1'b0;
  int cycCount = 0;
  int vecCount = 0, failCount = 0;
  string curReq = "R12";

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cycleStart = autoPulse || manualStart;

  always @(posedge clk) begin
    #1;
    cycCount++;
    autoPulse = autoStart && (cycCount % 16 == 0);
  end

  hbridge_ctrl #(.DEAD_CYCLES(DEAD), .BLANK_CYCLES(BLANK), .SYNC_STAGES(2)) u_hbridge_ctrl (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .dirIn(dirIn), .disableIn(disableIn),
    .fourQuad(fourQuad), .scDetect(scDetect), .otDetect(otDetect),
    .scEnable(scEnable), .otEnable(otEnable), .ocTrip(ocTrip), .cycleStart(cycleStart),
    .highA(highA), .lowA(lowA), .highB(highB), .lowB(lowB),
    .faultFlag(faultFlag), .scFlag(scFlag), .otFlag(otFlag)
  );

  // Behavioural reference: input delay queues, integer leg states.
  bit pwmQ[$], dirQ[$], disQ[$];
  bit mDisPrev, mSc, mOt, mOc;
  int mUp[2], mDn[2], mWait[2], want[2];
  int mQuiet = 1000;
  bit pS, dS, xS, off, clr, moved;
  int oldUp, oldDn;

  task automatic modelReset();
    pwmQ = '{0, 0}; dirQ = '{0, 0}; disQ = '{0, 0};
    mDisPrev = 0; mSc = 0; mOt = 0; mOc = 0; mQuiet = 1000;
    for (int i = 0; i < 2; i++) begin mUp[i] = 0; mDn[i] = 0; mWait[i] = 0; end
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      pS = pwmQ[0]; dS = dirQ[0]; xS = disQ[0];
      off = xS || mSc || mOt || mOc;
      // 0 = off, 1 = upper, 2 = lower
      if (off) begin want[0] = 0; want[1] = 0; end
      else if (fourQuad) begin want[0] = dS ? 1 : 2; want[1] = dS ? 2 : 1; end
      else if (dS) begin want[0] = 1; want[1] = pS ? 2 : 1; end
      else begin want[1] = 1; want[0] = pS ? 2 : 1; end
      clr = mDisPrev && !xS;
      mOc = cycleStart ? 1'b0 : (mOc || (ocTrip && mQuiet > BLANK));
      mSc = (mSc && !clr) || (scDetect && scEnable);
      mOt = (mOt && !clr) || (otDetect && otEnable);
      moved = 0;
      for (int i = 0; i < 2; i++) begin
        oldUp = mUp[i]; oldDn = mDn[i];
        if ((mUp[i] == 1 && want[i] != 1) || (mDn[i] == 1 && want[i] != 2)) begin
          if (want[i] != 1) mUp[i] = 0;
          if (want[i] != 2) mDn[i] = 0;
          mWait[i] = DEAD - 1;
        end else if (mWait[i] > 0) mWait[i]--;
        else if (mUp[i] == 0 && mDn[i] == 0) begin
          mUp[i] = (want[i] == 1) ? 1 : 0;
          mDn[i] = (want[i] == 2) ? 1 : 0;
        end
        if (oldUp != mUp[i] || oldDn != mDn[i]) moved = 1;
      end
      if (moved) mQuiet = 0; else if (mQuiet < 1000) mQuiet++;
      mDisPrev = xS;
      void'(pwmQ.pop_front()); pwmQ.push_back(pwmIn);
      void'(dirQ.pop_front()); dirQ.push_back(dirIn);
      void'(disQ.pop_front()); disQ.push_back(disableIn);
    end
  end

  logic [6:0] actV, expV;
  always @(negedge clk) begin
    actV = {highA, lowA, highB, lowB, faultFlag, scFlag, otFlag};
    expV = {mUp[0][0], mDn[0][0], mUp[1][0], mDn[1][0], mSc || mOt, mSc, mOt};
    vecCount++;
    if (actV !== expV) begin
      failCount++;
      $display("FAIL %s cycle %0d: {hA,lA,hB,lB,flt,sc,ot} got %b exp %b", curReq, cycCount, actV, expV);
    end
  end

  task automatic check(input bit ok, input string req, input logic [6:0] act, input logic [6:0] exp);
    vecCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s directed: got %b exp %b", req, act, exp);
    end
  endtask

  function automatic logic [6:0] outs();
    return {highA, lowA, highB, lowB, faultFlag, scFlag, otFlag};
  endfunction

  task automatic waitCyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: got hang exp completion");
    finishRun();
  end

  initial begin
    waitCyc(3);
    check(outs() == 7'b0, "R12", outs(), 7'b0);
    rstN = 1'b1;
    waitCyc(2);

    curReq = "R1"; fourQuad = 0; dirIn = 1;
    for (int k = 0; k < 4; k++) begin pwmIn = 1; waitCyc(6 + 2*k); pwmIn = 0; waitCyc(14 - 2*k); end
    pwmIn = 1; waitCyc(12);
    check(highA && !lowA && lowB && !highB, "R1", outs(), 7'b1001000);

    curReq = "R2"; dirIn = 0;
    for (int k = 0; k < 3; k++) begin pwmIn = 1; waitCyc(9); pwmIn = 0; waitCyc(7); end
    pwmIn = 1; waitCyc(12);
    check(lowA && highB && !highA && !lowB, "R2", outs(), 7'b0110000);

    curReq = "R3"; pwmIn = 0; waitCyc(12);
    check(highA && highB && !lowA && !lowB, "R3", outs(), 7'b1010000);

    curReq = "R4"; fourQuad = 1; pwmIn = 1;
    for (int k = 0; k < 4; k++) begin dirIn = 1; waitCyc(10); dirIn = 0; waitCyc(12); end
    dirIn = 1; waitCyc(10); pwmIn = 0; waitCyc(8);
    check(highA && lowB && !lowA && !highB, "R4", outs(), 7'b1001000);
    pwmIn = 1;

    curReq = "R5"; fourQuad = 0; dirIn = 1;
    for (int k = 0; k < 6; k++) begin pwmIn = ~pwmIn; waitCyc(1 + k); end
    pwmIn = 1; waitCyc(12);

    curReq = "R6"; disableIn = 1; waitCyc(3);
    check(outs() == 7'b0, "R6", outs(), 7'b0);
    waitCyc(5); disableIn = 0; waitCyc(10);

    curReq = "R7"; scDetect = 1; waitCyc(1); scDetect = 0; waitCyc(2);
    check(scFlag && faultFlag && !otFlag && !highA && !lowB, "R7", outs(), 7'b0000110);
    waitCyc(10);
    check(scFlag, "R7", outs(), 7'b0000110);

    curReq = "R8"; disableIn = 1; waitCyc(4); disableIn = 0; waitCyc(5);
    check(!scFlag && !faultFlag, "R8", outs(), 7'b1001000);
    curReq = "R7"; otDetect = 1; waitCyc(1); otDetect = 0; waitCyc(8);
    check(otFlag && faultFlag && !scFlag, "R7", outs(), 7'b0000101);
    curReq = "R8"; disableIn = 1; waitCyc(3); disableIn = 0; otDetect = 1;
    waitCyc(6); otDetect = 0; waitCyc(2);
    check(otFlag, "R8", outs(), 7'b0000101);
    disableIn = 1; waitCyc(4); disableIn = 0; waitCyc(10);
    check(!faultFlag && highA && lowB, "R8", outs(), 7'b1001000);

    curReq = "R9"; scEnable = 0; otEnable = 0;
    scDetect = 1; otDetect = 1; waitCyc(6); scDetect = 0; otDetect = 0; waitCyc(2);
    check(!faultFlag && !scFlag && !otFlag && highA && lowB, "R9", outs(), 7'b1001000);
    scEnable = 1; otEnable = 1;

    curReq = "R10"; autoStart = 0; waitCyc(20);
    ocTrip = 1; waitCyc(1); ocTrip = 0; waitCyc(1);
    check(!highA && !lowA && !highB && !lowB && !faultFlag, "R10", outs(), 7'b0);
    waitCyc(6);
    check(!highA && !lowB, "R10", outs(), 7'b0);
    manualStart = 1; waitCyc(1); manualStart = 0; waitCyc(4);
    check(highA && lowB && !faultFlag, "R10", outs(), 7'b1001000);

    curReq = "R11"; waitCyc(20);
    pwmIn = 0; waitCyc(3);
    ocTrip = 1; waitCyc(3); ocTrip = 0; waitCyc(6);
    check(highA && highB && !faultFlag, "R11", outs(), 7'b1010000);
    manualStart = 1; waitCyc(1); manualStart = 0; autoStart = 1;

    curReq = "R1"; waitCyc(30);
    finishRun();
  end

endmodule